// File: doc/BRIEF.md
# Serial Port Interrupt Request Unit

This block produces the interrupt requests of a FIFO-buffered serial port that runs in either asynchronous or synchronous mode. The receive and transmit datapaths report six conditions with one-cycle event pulses: transmit FIFO empty, receive FIFO full, data ready, receive error, break and overrun. The block latches each condition in a sticky status flag. Software clears a flag by reading the status word and then writing 0 to that bit.

Three enable bits from the port's control register gate the flags onto four separate request lines: transmit, receive, break and error. The receive-interrupt enable and the error-interrupt enable share the gating of the error and break lines. The data-ready flag counts toward the receive request only in asynchronous mode. A registered 3-bit code names the highest-priority pending request. Only the receive and transmit conditions drive activation requests to a transfer controller, and an acknowledge pulse from that controller clears the flag that raised the request.

Top module: `sio_irq_unit`

## Requirements
- R1: A 1 on `set_i[k]` during a clock edge sets status flag k. The flag stays at 1 until it is cleared, and `stat_o[k]` shows it from the next clock on. Bit positions: 0 transmit empty, 1 receive full, 2 data ready, 3 receive error, 4 break, 5 overrun.
- R2: A write with `wr_data_i[k]`=0 clears flag k only if `stat_o[k]` was 1 during the most recent read strobe `rd_i`. Writing 1 to a bit leaves the flag unchanged. Writing 0 to a flag that has not been read as 1 also leaves it unchanged.
- R3: If a set pulse and a clear (by write or by acknowledge) reach the same flag in the same cycle, the flag stays set.
- R4: `txi_o` = `en_tx_i` AND transmit-empty flag.
- R5: `rxi_o` = `en_rx_i` AND (receive-full flag OR (data-ready flag AND `async_i`)). In synchronous mode (`async_i`=0) the data-ready flag has no effect on `rxi_o`.
- R6: `bri_o` = (`en_rx_i` OR `en_err_i`) AND (break flag OR overrun flag).
- R7: `eri_o` = (`en_rx_i` OR `en_err_i`) AND receive-error flag. With `en_rx_i`=0 and `en_err_i`=1, error and break requests can still assert but `rxi_o` cannot.
- R8: `prio_o` takes the code of the highest pending request one clock after the requests change. The codes are 0 for none, 1 for error, 2 for receive, 3 for break and 4 for transmit, and a lower code wins over a higher one.
- R9: `dma_rx_req_o` = `en_rx_i` AND receive-full flag, and `dma_tx_req_o` = `txi_o`. The error and break conditions never raise a transfer request.
- R10: A pulse on `dma_ack_rx_i` clears the receive-full flag and a pulse on `dma_ack_tx_i` clears the transmit-empty flag, so the matching request is low from the next clock. The acknowledge needs no prior read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| set_i | input | 6 | Event pulses that set the flags |
| rd_i | input | 1 | Status read strobe; captures which flags are eligible to be cleared |
| wr_i | input | 1 | Status write strobe |
| wr_data_i | input | 6 | Status write data; a 0 clears a flag that was read as 1 |
| en_tx_i | input | 1 | Transmit interrupt enable |
| en_rx_i | input | 1 | Receive interrupt enable |
| en_err_i | input | 1 | Receive error interrupt enable |
| async_i | input | 1 | 1 selects asynchronous mode |
| dma_ack_rx_i | input | 1 | Transfer controller acknowledge for receive |
| dma_ack_tx_i | input | 1 | Transfer controller acknowledge for transmit |
| stat_o | output | 6 | Current status flags |
| txi_o | output | 1 | Transmit request |
| rxi_o | output | 1 | Receive request |
| bri_o | output | 1 | Break/overrun request |
| eri_o | output | 1 | Receive error request |
| prio_o | output | 3 | Code of the highest pending request |
| dma_rx_req_o | output | 1 | Receive transfer activation request |
| dma_tx_req_o | output | 1 | Transmit transfer activation request |

## Verification
The bench sweeps all 64 flag patterns against all eight enable combinations in both modes and compares each request line and the priority code against arithmetic expectations. A design that let data-ready raise a request in synchronous mode would fail there, and so would one that gated break or error with a single enable or ranked sources in the wrong order. Directed cases clear a flag that was never read, write 1 to an armed flag, and collide a set pulse with a clear or an acknowledge. A design that clears on any write, or lets the clear win a collision, would drop a flag that has to stay at 1.

// File: rtl/sio_irq_pkg.sv
package sio_irq_pkg;
  localparam int unsigned NUM_FLAGS = 6;
  localparam int unsigned PRIO_W    = 3;
  localparam int unsigned F_TXE = 0;
  localparam int unsigned F_RXF = 1;
  localparam int unsigned F_DR  = 2;
  localparam int unsigned F_ERR = 3;
  localparam int unsigned F_BRK = 4;
  localparam int unsigned F_OVR = 5;

  typedef enum logic [PRIO_W-1:0] {
    PRIO_NONE = 3'd0,
    PRIO_ERR  = 3'd1,
    PRIO_RX   = 3'd2,
    PRIO_BRK  = 3'd3,
    PRIO_TX   = 3'd4
  } prio_e;

  typedef struct packed {
    logic eri;
    logic rxi;
    logic bri;
    logic txi;
  } req_t;
endpackage

// File: rtl/sio_irq_flags.sv
module sio_irq_flags
  import sio_irq_pkg::*;
#(
  parameter int unsigned NF = NUM_FLAGS
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [NF-1:0] set_i,
  input  logic          rd_i,
  input  logic          wr_i,
  input  logic [NF-1:0] wr_data_i,
  input  logic [NF-1:0] ack_i,
  output logic [NF-1:0] flag_o
);
  logic [NF-1:0] arm_q;

  for (genvar k = 0; k < NF; k++) begin : g_flag
    logic clr;
    assign clr = (wr_i & ~wr_data_i[k] & arm_q[k]) | ack_i[k];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        flag_o[k] <= 1'b0;
        arm_q[k]  <= 1'b0;
      end else begin
        flag_o[k] <= set_i[k] | (flag_o[k] & ~clr);
        if (rd_i)     arm_q[k] <= flag_o[k];
        else if (clr) arm_q[k] <= 1'b0;
      end
    end

    // R1
    set_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[k] |=> flag_o[k]);
    // R2
    unread_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flag_o[k] && wr_i && !arm_q[k] && !ack_i[k]) |=> flag_o[k]);
    // R10
    ack_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ack_i[k] && !set_i[k]) |=> !flag_o[k]);
  end
endmodule

// File: rtl/sio_irq_gate.sv
module sio_irq_gate
  import sio_irq_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_FLAGS-1:0] flag_i,
  input  logic                 en_tx_i,
  input  logic                 en_rx_i,
  input  logic                 en_err_i,
  input  logic                 async_i,
  output req_t                 req_o
);
  logic rx_side_en;
  assign rx_side_en = en_rx_i | en_err_i;

  always_comb begin
    req_o.txi = en_tx_i & flag_i[F_TXE];
    // data-ready only counts in async mode
    req_o.rxi = en_rx_i & (flag_i[F_RXF] | (flag_i[F_DR] & async_i));
    req_o.bri = rx_side_en & (flag_i[F_BRK] | flag_i[F_OVR]);
    req_o.eri = rx_side_en & flag_i[F_ERR];
  end

  // R5
  rx_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_rx_i |-> !req_o.rxi);
  // R7
  err_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_rx_i && !en_err_i) |-> !(req_o.eri || req_o.bri));
  // R4
  tx_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flag_i[F_TXE] |-> !req_o.txi);
endmodule

// File: rtl/sio_irq_prio.sv
module sio_irq_prio
  import sio_irq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  req_t              req_i,
  output logic [PRIO_W-1:0] prio_o
);
  prio_e prio_d;

  always_comb begin
    if (req_i.eri)      prio_d = PRIO_ERR;
    else if (req_i.rxi) prio_d = PRIO_RX;
    else if (req_i.bri) prio_d = PRIO_BRK;
    else if (req_i.txi) prio_d = PRIO_TX;
    else                prio_d = PRIO_NONE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prio_o <= PRIO_NONE;
    else         prio_o <= prio_d;
  end

  // R8
  prio_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prio_o <= 3'd4);
  // R8
  prio_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i.eri |=> (prio_o == 3'd1));
  // R8
  prio_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i == '0) |=> (prio_o == 3'd0));
endmodule

// File: rtl/sio_irq_unit.sv
module sio_irq_unit
  import sio_irq_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_FLAGS-1:0] set_i,
  input  logic                 rd_i,
  input  logic                 wr_i,
  input  logic [NUM_FLAGS-1:0] wr_data_i,
  input  logic                 en_tx_i,
  input  logic                 en_rx_i,
  input  logic                 en_err_i,
  input  logic                 async_i,
  input  logic                 dma_ack_rx_i,
  input  logic                 dma_ack_tx_i,
  output logic [NUM_FLAGS-1:0] stat_o,
  output logic                 txi_o,
  output logic                 rxi_o,
  output logic                 bri_o,
  output logic                 eri_o,
  output logic [PRIO_W-1:0]    prio_o,
  output logic                 dma_rx_req_o,
  output logic                 dma_tx_req_o
);
  logic [NUM_FLAGS-1:0] ack_vec;
  req_t                 req;

  always_comb begin
    ack_vec        = '0;
    ack_vec[F_TXE] = dma_ack_tx_i;
    ack_vec[F_RXF] = dma_ack_rx_i;
  end

  sio_irq_flags #(.NF(NUM_FLAGS)) u_flags (
    .clk_i, .rst_ni, .set_i, .rd_i, .wr_i, .wr_data_i,
    .ack_i(ack_vec), .flag_o(stat_o)
  );

  sio_irq_gate u_gate (
    .clk_i, .rst_ni, .flag_i(stat_o), .en_tx_i, .en_rx_i, .en_err_i,
    .async_i, .req_o(req)
  );

  sio_irq_prio u_prio (
    .clk_i, .rst_ni, .req_i(req), .prio_o
  );

  assign txi_o        = req.txi;
  assign rxi_o        = req.rxi;
  assign bri_o        = req.bri;
  assign eri_o        = req.eri;
  assign dma_tx_req_o = req.txi;
  assign dma_rx_req_o = en_rx_i & stat_o[F_RXF];

  // R9
  dma_rx_route_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_rx_req_o |-> rxi_o);
  // R10
  dma_ack_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dma_ack_rx_i && !set_i[F_RXF]) |=> !dma_rx_req_o);
endmodule

// File: tb/sio_irq_unit_bench.sv
module sio_irq_unit_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] set_v = '0, wr_data = '0, stat;
  logic       rd = 0, wr = 0, en_tx = 0, en_rx = 0, en_err = 0, async_m = 0;
  logic       ack_rx = 0, ack_tx = 0;
  logic       txi, rxi, bri, eri, dma_rx, dma_tx;
  logic [2:0] prio;
  int         n_run = 0, n_fail = 0;
  bit         done = 0;

  always #4 clk = ~clk;

  sio_irq_unit u_sio_irq_unit (
    .clk_i(clk), .rst_ni(rst_n), .set_i(set_v), .rd_i(rd), .wr_i(wr),
    .wr_data_i(wr_data), .en_tx_i(en_tx), .en_rx_i(en_rx), .en_err_i(en_err),
    .async_i(async_m), .dma_ack_rx_i(ack_rx), .dma_ack_tx_i(ack_tx),
    .stat_o(stat), .txi_o(txi), .rxi_o(rxi), .bri_o(bri), .eri_o(eri),
    .prio_o(prio), .dma_rx_req_o(dma_rx), .dma_tx_req_o(dma_tx)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  // returns {eri,rxi,bri,txi}
  function automatic logic [3:0] model_req(logic [5:0] f, logic t, logic r, logic e, logic a);
    logic re = r | e;
    return {re & f[3], r & (f[1] | (f[2] & a)), re & (f[4] | f[5]), t & f[0]};
  endfunction

  function automatic logic [2:0] model_prio(logic [3:0] q);
    if (q[3]) return 3'd1;
    if (q[2]) return 3'd2;
    if (q[1]) return 3'd3;
    if (q[0]) return 3'd4;
    return 3'd0;
  endfunction

  task automatic clear_all();
    rd = 1; step(); rd = 0;
    wr = 1; wr_data = '0; step(); wr = 0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [3:0] q;
    repeat (2) step();
    rst_n = 1; step();
    // reset state (R1, R8)
    chk("R1 reset stat", {2'b0, stat}, 8'h00);
    chk("R8 reset prio", {5'b0, prio}, 8'h00);
    chk("R4 reset reqs", {2'b0, eri, rxi, bri, txi, dma_rx, dma_tx}, 8'h00);

    // exhaustive sweep: R1 R4 R5 R6 R7 R8 R9
    for (int a = 0; a < 2; a++) begin
      for (int e = 0; e < 8; e++) begin
        for (int p = 0; p < 64; p++) begin
          clear_all();
          async_m = a[0]; en_tx = e[0]; en_rx = e[1]; en_err = e[2];
          set_v = p[5:0]; step(); set_v = '0;
          q = model_req(p[5:0], e[0], e[1], e[2], a[0]);
          chk("R1 flags", {2'b0, stat}, {2'b0, p[5:0]});
          chk("R4 txi", {7'b0, txi}, {7'b0, q[0]});
          chk("R5 rxi", {7'b0, rxi}, {7'b0, q[2]});
          chk("R6 bri", {7'b0, bri}, {7'b0, q[1]});
          chk("R7 eri", {7'b0, eri}, {7'b0, q[3]});
          chk("R9 dma", {6'b0, dma_rx, dma_tx}, {6'b0, e[1] & p[1], q[0]});
          step();
          chk("R8 prio", {5'b0, prio}, {5'b0, model_prio(q)});
        end
      end
    end

    // R2: unread write does not clear
    clear_all();
    en_tx = 1; en_rx = 1; en_err = 1; async_m = 1;
    set_v = 6'h3F; step(); set_v = '0;
    wr = 1; wr_data = '0; step(); wr = 0;
    chk("R2 unread write keeps", {2'b0, stat}, 8'h3F);
    // R2: write 1 with armed flags keeps; write 0 to selected bits clears them only
    rd = 1; step(); rd = 0;
    wr = 1; wr_data = 6'h3F; step(); wr = 0;
    chk("R2 write one keeps", {2'b0, stat}, 8'h3F);
    wr = 1; wr_data = 6'b110101; step(); wr = 0;
    chk("R2 selective clear", {2'b0, stat}, 8'h35);
    // flag set after the read is not armed
    set_v = 6'h02; step(); set_v = '0;
    rd = 1; step(); rd = 0;
    set_v = 6'h08; step(); set_v = '0;
    wr = 1; wr_data = 6'h00; step(); wr = 0;
    chk("R2 late flag kept", {2'b0, stat}, 8'h08);

    // R3: set and write clear collide
    clear_all();
    set_v = 6'h10; step(); set_v = '0;
    rd = 1; step(); rd = 0;
    wr = 1; wr_data = '0; set_v = 6'h10; step(); wr = 0; set_v = '0;
    chk("R3 set beats write clear", {2'b0, stat}, 8'h10);

    // R10: acknowledge clears rx full and tx empty
    clear_all();
    en_tx = 1; en_rx = 1; async_m = 0;
    set_v = 6'h03; step(); set_v = '0;
    chk("R9 dma both", {6'b0, dma_rx, dma_tx}, 8'h03);
    ack_rx = 1; step(); ack_rx = 0;
    chk("R10 ack rx", {2'b0, stat, dma_rx, rxi}, {2'b0, 6'h01, 2'b00});
    ack_tx = 1; step(); ack_tx = 0;
    chk("R10 ack tx", {2'b0, stat, dma_tx, txi}, {2'b0, 6'h00, 2'b00});
    // R3: ack collides with set
    set_v = 6'h02; step();
    ack_rx = 1; step(); ack_rx = 0; set_v = '0;
    chk("R3 set beats ack", {2'b0, stat}, 8'h02);

    // R5: data-ready in sync mode ignored, async counts
    clear_all();
    en_rx = 1; async_m = 0;
    set_v = 6'h04; step(); set_v = '0;
    chk("R5 sync dr ignored", {6'b0, rxi, dma_rx}, 8'h00);
    async_m = 1; step();
    chk("R5 async dr counts", {6'b0, rxi, dma_rx}, 8'h02);
    chk("R8 prio rx", {5'b0, prio}, 8'h02);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule